// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous memory. A cycle with the clock enable high and the advance strobe low loads a new external address and starts a burst. The loaded address appears on the output one cycle later. Each following enabled cycle with the advance strobe high steps the two low-order bits to the next position in the burst. The bits above them stay at their loaded value.

A mode input selects the burst order. With the mode low, the low bits count up by one and wrap from 3 back to 0. With the mode high, each beat's low bits are the start offset XORed with the beat index. Either order may begin at any of the four offsets. After the fourth beat, further advance cycles go on wrapping inside the same four-address group. When the clock enable is low the edge is ignored and everything is held.

Control is a two-state machine. ST_IDLE is the state after reset, before any burst has been loaded. ST_BURST is the state once an address has been loaded. The transitions are:
- LOAD: any enabled cycle with the advance strobe low, taken from either state.
- STEP: ST_BURST to itself on an enabled advance.
- STALL: any state to itself when the clock enable is low.
- DESELECT HOLD: ST_IDLE to itself on an enabled advance.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after its release, before any load, `cur_addr` is all zeros.
- R2: An enabled cycle (`clk_en`=1) with `adv`=0 puts `ext_addr` on `cur_addr` after the next rising edge. This applies in either state and restarts the beat index at 0.
- R3: With `order_sel`=0, each enabled cycle with `adv`=1 in a burst sets `cur_addr[1:0]` to the previous value plus 1, modulo 4. For example, a start of 2'b10 gives 10, 11, 00, 01.
- R4: With `order_sel`=1, the low bits of beat k are the start low bits XOR k, with k counted 0 to 3. For example, a start of 2'b01 gives 01, 00, 11, 10.
- R5: Advance cycles never change `cur_addr[ADDR_W-1:2]`; those bits keep the value loaded at burst start.
- R6: A cycle with `clk_en`=0 leaves `cur_addr` unchanged, whatever the values of `adv`, `ext_addr` and `order_sel`.
- R7: A fifth advance returns the low bits to the start offset, and the sequence keeps repeating in the same four-address group.
- R8: An enabled advance before any load since reset leaves `cur_addr` unchanged.
- R9: A load in the middle of a burst restarts the order from beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable; when low the edge is ignored |
| adv | input | 1 | 0 = load `ext_addr` and start a burst, 1 = advance to the next beat |
| ext_addr | input | ADDR_W | External start address |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| cur_addr | output | ADDR_W | Current beat address (registered) |

## Verification
The bench runs all four start offsets in both orders for more than four advances. A design that wrapped out of the group, or that carried into bit 2, would then show a wrong fifth beat or a changed upper field. Stalls placed in the middle of a burst catch a design that lets a disabled edge advance the beat or reload the address. Advance cycles before the first load catch a design that counts from a stale start. A reload in the middle of a burst catches a beat counter that is not cleared, which would make the new burst start part-way through its order.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Two address bits index the four beats of one burst.
    localparam int BEAT_W    = 2;
    localparam int BURST_LEN = 1 << BEAT_W;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [BEAT_W-1:0] beat
);

    // The index wraps naturally at 2**BEAT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clr) begin
            beat <= '0;
        end else if (inc) begin
            beat <= beat + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic              interleave,
    output logic [BEAT_W-1:0] low_out
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear: offset plus index, wrapping in the group.
    assign lin_low = start_low + beat_idx;
    // Interleaved: offset XOR index.
    assign ilv_low = start_low ^ beat_idx;

    always_comb begin
        low_out = interleave ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       adv,
    output seq_state_e state,
    output logic       do_load,
    output logic       do_step
);

    seq_state_e state_nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic: LOAD, STEP, STALL and DESELECT HOLD.
    always_comb begin
        state_nxt = state;
        if (clk_en) begin
            unique case (state)
                ST_IDLE:  state_nxt = adv ? ST_IDLE : ST_BURST;
                ST_BURST: state_nxt = ST_BURST;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // Output process: datapath strobes.
    always_comb begin
        do_load = 1'b0;
        do_step = 1'b0;
        if (clk_en) begin
            unique case (state)
                ST_IDLE: begin
                    do_load = !adv;
                end
                ST_BURST: begin
                    do_load = !adv;
                    do_step = adv;
                end
                default: begin
                    do_load = 1'b0;
                    do_step = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              adv,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int BW = BEAT_W;

    seq_state_e        fsm_state;
    logic              do_load;
    logic              do_step;
    logic [BW-1:0]     beat;
    logic [BW-1:0]     beat_nxt;
    logic [BW-1:0]     low_nxt;
    logic [ADDR_W-1:0] start_addr;

    burst_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .adv     (adv),
        .state   (fsm_state),
        .do_load (do_load),
        .do_step (do_step)
    );

    burst_beat_ctr #(.BEAT_W(BW)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_load),
        .inc   (do_step),
        .beat  (beat)
    );

    assign beat_nxt = beat + BW'(1);

    burst_order_gen #(.BEAT_W(BW)) u_order (
        .start_low  (start_addr[BW-1:0]),
        .beat_idx   (beat_nxt),
        .interleave (order_sel),
        .low_out    (low_nxt)
    );

    // Start address and current address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            cur_addr   <= '0;
        end else if (do_load) begin
            start_addr <= ext_addr;
            cur_addr   <= ext_addr;
        end else if (do_step) begin
            cur_addr   <= {start_addr[ADDR_W-1:BW], low_nxt};
        end
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              adv,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              order_sel,
    input logic [ADDR_W-1:0] cur_addr,
    input seq_state_e        state,
    input logic [BEAT_W-1:0] beat
);

    localparam int BW = BEAT_W;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> cur_addr == '0);  // R1

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !adv |=> cur_addr == $past(ext_addr));  // R2

    AST_LOAD_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !adv |=> beat == '0);  // R9

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && adv && !order_sel && state == ST_BURST
        |=> cur_addr[BW-1:0] == $past(cur_addr[BW-1:0]) + BW'(1));  // R3

    AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && adv && order_sel && state == ST_BURST
        |=> cur_addr[BW-1:0] == ($past(cur_addr[BW-1:0]) ^
            ($past(beat[0]) ? BW'(3) : BW'(1))));  // R4

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && adv |=> $stable(cur_addr[ADDR_W-1:BW]));  // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(cur_addr));  // R6

    AST_IDLE_ADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && adv && state == ST_IDLE |=> $stable(cur_addr));  // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .adv       (adv),
    .ext_addr  (ext_addr),
    .order_sel (order_sel),
    .cur_addr  (cur_addr),
    .state     (fsm_state),
    .beat      (beat)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en = 1'b0;
    logic              adv = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] cur_addr;

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural reference state.
    bit m_active = 0;
    int m_start  = 0;
    int m_beat   = 0;
    int m_addr   = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .adv       (adv),
        .ext_addr  (ext_addr),
        .order_sel (order_sel),
        .cur_addr  (cur_addr)
    );

    task automatic check_val(input string req, input int exp);
        n_cmp++;
        if (cur_addr !== exp[ADDR_W-1:0]) begin
            n_bad++;
            $display("FAIL %s: cur_addr=%h expected=%h at %0t", req, cur_addr, exp[ADDR_W-1:0], $time);
        end
    endtask

    // Drive one cycle, update the model at the edge, then compare at the negedge.
    task automatic cyc(input bit en, input bit a, input int addr, input bit mode, input string req);
        int low;
        clk_en    = en;
        adv       = a;
        ext_addr  = addr[ADDR_W-1:0];
        order_sel = mode;
        @(posedge clk);
        if (!rst_n) begin
            m_active = 0; m_start = 0; m_beat = 0; m_addr = 0;
        end else if (en) begin
            if (!a) begin
                m_active = 1;
                m_start  = addr & ((1 << ADDR_W) - 1);
                m_beat   = 0;
                m_addr   = m_start;
            end else if (m_active) begin
                m_beat = (m_beat + 1) % 4;
                if (mode) low = (m_start % 4) ^ m_beat;
                else      low = ((m_start % 4) + m_beat) % 4;
                m_addr = (m_start - (m_start % 4)) + low;
            end
        end
        @(negedge clk);
        check_val(req, m_addr);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: held in reset
        repeat (3) cyc(1, 0, 8'hFF, 0, "R1");
        rst_n = 1'b1;
        // R8: advances before any load leave zero
        repeat (3) cyc(1, 1, 8'h77, 0, "R8");
        cyc(1, 1, 8'h77, 1, "R8");

        // R3 explicit table example: start low 10 -> 10,11,00,01
        cyc(1, 0, 8'h52, 0, "R2");
        check_val("R2", 8'h52);
        cyc(1, 1, 0, 0, "R3"); check_val("R3", 8'h53);
        cyc(1, 1, 0, 0, "R3"); check_val("R3", 8'h50);
        cyc(1, 1, 0, 0, "R3"); check_val("R3", 8'h51);
        cyc(1, 1, 0, 0, "R7"); check_val("R7", 8'h52);

        // R4 explicit table example: start low 01 -> 01,00,11,10
        cyc(1, 0, 8'hA5, 1, "R2");
        cyc(1, 1, 0, 1, "R4"); check_val("R4", 8'hA4);
        cyc(1, 1, 0, 1, "R4"); check_val("R4", 8'hA7);
        cyc(1, 1, 0, 1, "R4"); check_val("R4", 8'hA6);
        cyc(1, 1, 0, 1, "R7"); check_val("R7", 8'hA5);

        // All start offsets, both orders, six advances each (R3 R4 R5 R7)
        for (int mode = 0; mode < 2; mode++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1, 0, 8'hC0 + 16 * s + s, mode[0], "R2");
                for (int k = 0; k < 6; k++)
                    cyc(1, 1, 8'h3C, mode[0], mode ? "R4_R5" : "R3_R5");
            end
        end

        // R6: stalls mid-burst with changing inputs
        cyc(1, 0, 8'h6E, 0, "R2");
        cyc(1, 1, 0, 0, "R3");
        cyc(0, 0, 8'h11, 1, "R6");
        cyc(0, 1, 8'h22, 0, "R6");
        cyc(0, 0, 8'h33, 0, "R6");
        cyc(1, 1, 0, 0, "R3");
        cyc(1, 1, 0, 0, "R7");

        // R9: reload mid-burst restarts beat order
        cyc(1, 0, 8'h93, 1, "R2");
        cyc(1, 1, 0, 1, "R4");
        cyc(1, 1, 0, 1, "R4");
        cyc(1, 0, 8'h4A, 1, "R9"); check_val("R9", 8'h4A);
        cyc(1, 1, 0, 1, "R9"); check_val("R9", 8'h4B);
        cyc(1, 1, 0, 1, "R9"); check_val("R9", 8'h48);
        cyc(1, 0, 8'h1D, 0, "R9");
        cyc(1, 1, 0, 0, "R9"); check_val("R9", 8'h1E);

        // R1: reset again mid-burst, then idle advance
        rst_n = 1'b0;
        cyc(1, 1, 0, 0, "R1");
        rst_n = 1'b1;
        cyc(1, 1, 0, 0, "R8");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule